// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This block turns the attribute bits of a page-table descriptor into the final memory attributes that the rest of the memory system uses. Its outputs are a memory type (strongly ordered, device or normal), a shareable flag, inner and outer cacheability, and the non-secure flag. The block looks up a 3-bit index built as {TEX[0], C, B}.

The remap has two stages. A primary register gives each of the eight indices a memory type, and it also holds the shareable values for device and normal memory. A second register, the normal register, gives each index its inner and outer cacheability. The second stage is used only when the first stage resolves the type as normal. When remap is disabled, both registers are ignored and a fixed built-in decode is used.

Software writes and reads both registers through a simple port. The attribute outputs are combinational from the inputs and the current register contents. A register write takes effect at the next clock edge. The reset contents make the enabled remap give the same results as the built-in decode.

Top module: `attr_remap`

## Requirements
- R1: After reset the primary register reads 0x000AAAA4 and the normal register reads 0x40E040E0. reg_sel selects the register: 0 is primary, 1 is normal. reg_rdata is combinational from reg_sel.
- R2: A write with reg_we=1 stores reg_wdata into the selected register at the rising clock edge. In the cycle of the write, reg_rdata and the attribute outputs still reflect the old register value.
- R3: With remap_en=0, the registers have no effect and the output follows a fixed decode of the index {tex0,c,b}. Index 000 gives strongly ordered. Index 001 gives device. Index 010 gives normal with cacheability 10. Index 011 gives normal with 11. Index 111 gives normal with 01. Indices 100, 101 and 110 give normal with 00. Inner and outer cacheability are equal. shareable_out equals shareable_in for device and normal.
- R4: With remap_en=1, mem_type comes from primary bits [2n+1:2n] for index n. The type codes are 00 strongly ordered, 01 device and 10 normal. The reserved code 11 is output as 10, so mem_type is never 11.
- R5: Strongly ordered is always output as shareable. With remap_en=1, device memory takes primary bit 16 when shareable_in=0 and bit 17 when shareable_in=1. Normal memory takes bit 18 when shareable_in=0 and bit 19 when shareable_in=1.
- R6: With remap_en=1 and normal type, inner_cache equals normal register bits [2n+1:2n]. outer_cache equals bits [2n+17:2n+16]. The cacheability codes are 00 non-cacheable, 01 write-back write-allocate, 10 write-through and 11 write-back no-allocate.
- R7: For strongly ordered and device types, inner_cache and outer_cache are 00, whatever the normal register holds.
- R8: ns_out always equals ns_in.
- R9: With the reset register contents, remap_en=1 gives the same outputs as remap_en=0 for every index and shareable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| remap_en | input | 1 | Enables the register-based remap |
| tex0 | input | 1 | Descriptor TEX[0] bit |
| c_bit | input | 1 | Descriptor C bit |
| b_bit | input | 1 | Descriptor B bit |
| shareable_in | input | 1 | Descriptor shareable bit |
| ns_in | input | 1 | Descriptor non-secure bit |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 primary, 1 normal |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| mem_type | output | 2 | 00 strongly ordered, 01 device, 10 normal |
| shareable_out | output | 1 | Final shareable flag |
| inner_cache | output | 2 | Final inner cacheability |
| outer_cache | output | 2 | Final outer cacheability |
| ns_out | output | 1 | Non-secure flag, passed through |

## Verification
A register write and an attribute lookup that depends on that same register can occur in the same cycle. The bench sets up an enabled lookup of index 000 and drives a primary-register write in that cycle. The new value turns index 000 from strongly ordered into normal. Before the clock edge the outputs and reg_rdata must still show the old strongly ordered, shareable result. After the edge both must show the new value.

// File: rtl/attr_remap.sv
module attr_remap #(
  parameter int          REG_W    = 32,
  parameter logic [31:0] PRIM_RST = 32'h000AAAA4,
  parameter logic [31:0] NORM_RST = 32'h40E040E0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remap_en,
  input  logic             tex0,
  input  logic             c_bit,
  input  logic             b_bit,
  input  logic             shareable_in,
  input  logic             ns_in,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [1:0]       mem_type,
  output logic             shareable_out,
  output logic [1:0]       inner_cache,
  output logic [1:0]       outer_cache,
  output logic             ns_out
);
  localparam logic [1:0] T_SO  = 2'b00;
  localparam logic [1:0] T_DEV = 2'b01;
  localparam logic [1:0] T_NRM = 2'b10;

  logic [REG_W-1:0] prim_q, norm_q;
  logic [2:0]       idx;
  logic [1:0]       fix_type, fix_cache, map_type, sel_type;

  assign idx = {tex0, c_bit, b_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= PRIM_RST[REG_W-1:0];
      norm_q <= NORM_RST[REG_W-1:0];
    end else if (reg_we) begin
      if (reg_sel) norm_q <= reg_wdata;
      else         prim_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? norm_q : prim_q;

  always_comb begin
    case (idx)
      3'b000:  begin fix_type = T_SO;  fix_cache = 2'b00; end
      3'b001:  begin fix_type = T_DEV; fix_cache = 2'b00; end
      3'b010:  begin fix_type = T_NRM; fix_cache = 2'b10; end
      3'b011:  begin fix_type = T_NRM; fix_cache = 2'b11; end
      3'b111:  begin fix_type = T_NRM; fix_cache = 2'b01; end
      default: begin fix_type = T_NRM; fix_cache = 2'b00; end
    endcase
  end

  assign map_type = (prim_q[{idx, 1'b0} +: 2] == 2'b11) ? T_NRM : prim_q[{idx, 1'b0} +: 2];
  assign sel_type = remap_en ? map_type : fix_type;
  assign mem_type = sel_type;

  always_comb begin
    if (sel_type == T_SO)
      shareable_out = 1'b1;
    else if (!remap_en)
      shareable_out = shareable_in;
    else if (sel_type == T_DEV)
      shareable_out = prim_q[16 + int'(shareable_in)];
    else
      shareable_out = prim_q[18 + int'(shareable_in)];
  end

  always_comb begin
    if (!remap_en) begin
      inner_cache = fix_cache;
      outer_cache = fix_cache;
    end else if (sel_type == T_NRM) begin
      inner_cache = norm_q[{idx, 1'b0} +: 2];
      outer_cache = norm_q[16 + 2 * int'(idx) +: 2];
    end else begin
      inner_cache = 2'b00;
      outer_cache = 2'b00;
    end
  end

  assign ns_out = ns_in;
endmodule

module attr_remap_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             remap_en,
  input logic             tex0,
  input logic             c_bit,
  input logic             b_bit,
  input logic             ns_in,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [1:0]       mem_type,
  input logic             shareable_out,
  input logic [1:0]       inner_cache,
  input logic [1:0]       outer_cache,
  input logic             ns_out
);
  assert_ns_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ns_out == ns_in);

  assert_type_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_type != 2'b11);

  assert_so_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_type == 2'b00) |-> shareable_out);

  assert_nonnormal_uncached_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_type != 2'b10) |-> (inner_cache == 2'b00 && outer_cache == 2'b00));

  assert_fixed_so_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!remap_en && {tex0, c_bit, b_bit} == 3'b000) |-> (mem_type == 2'b00));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_sel != $past(reg_sel) || reg_rdata == $past(reg_wdata)));
endmodule

bind attr_remap attr_remap_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .remap_en(remap_en), .tex0(tex0), .c_bit(c_bit),
  .b_bit(b_bit), .ns_in(ns_in), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_type(mem_type),
  .shareable_out(shareable_out), .inner_cache(inner_cache),
  .outer_cache(outer_cache), .ns_out(ns_out)
);

// File: tb/attr_remap_tb.sv
module attr_remap_tb;
  logic clk = 0, rst_n = 0;
  logic remap_en = 0, tex0 = 0, c_bit = 0, b_bit = 0, shareable_in = 0, ns_in = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0] mem_type, inner_cache, outer_cache;
  logic shareable_out, ns_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  attr_remap u_dut (.*);

  // {en, idx[2:0], s, ns} -> {type[1:0], sh, inner[1:0], outer[1:0], ns}
  localparam logic [13:0] VEC [13] = '{
    14'b0_000_0_0_00_1_00_00_0, 14'b0_001_0_1_01_0_00_00_1,
    14'b0_010_1_0_10_1_10_10_0, 14'b0_011_0_0_10_0_11_11_0,
    14'b0_100_1_1_10_1_00_00_1, 14'b0_111_0_0_10_0_01_01_0,
    14'b1_000_0_1_00_1_00_00_1, 14'b1_001_1_0_01_1_00_00_0,
    14'b1_010_0_0_10_0_10_10_0, 14'b1_011_1_0_10_1_11_11_0,
    14'b1_101_0_1_10_0_00_00_1, 14'b1_110_1_0_10_1_00_00_0,
    14'b1_111_1_1_10_1_01_01_1
  };

  task automatic apply(input logic en, input logic [2:0] ix, input logic s, input logic ns);
    remap_en = en; {tex0, c_bit, b_bit} = ix; shareable_in = s; ns_in = ns;
  endtask

  task automatic chk_out(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {mem_type, shareable_out, inner_cache, outer_cache, ns_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [31:0] exp);
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata act=%h exp=%h", req, reg_rdata, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  localparam logic [31:0] P_NEW = 32'h0005AAD2;
  localparam logic [31:0] N_NEW = 32'h001200E1;

  initial begin
    #2000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    @(negedge clk); #1;
    reg_sel = 0; #1 chk_rd("R1", 32'h000AAAA4);
    reg_sel = 1; #1 chk_rd("R1", 32'h40E040E0);
    foreach (VEC[i]) begin
      apply(VEC[i][13], VEC[i][12:10], VEC[i][9], VEC[i][8]);
      #1 chk_out(VEC[i][13] ? "R9/R8" : "R3/R8", VEC[i][7:0]);
    end
    // same-cycle write and lookup
    @(negedge clk);
    apply(1, 3'b000, 0, 0);
    reg_we = 1; reg_sel = 0; reg_wdata = P_NEW;
    #1 chk_out("R2 old value in write cycle", 8'b00_1_00_00_0);
    chk_rd("R2 old rdata in write cycle", 32'h000AAAA4);
    @(negedge clk); reg_we = 0; #1;
    chk_rd("R2 new primary", P_NEW);
    chk_out("R2 new type after edge", 8'b10_1_00_00_0);
    write_reg(1, N_NEW); #1;
    chk_rd("R2 new normal", N_NEW);
    apply(1, 3'b000, 0, 0); #1 chk_out("R4/R5/R6 idx0 s0", 8'b10_1_01_10_0);
    apply(1, 3'b000, 1, 1); #1 chk_out("R5/R6 idx0 s1", 8'b10_0_01_10_1);
    apply(1, 3'b001, 0, 0); #1 chk_out("R5/R7 so", 8'b00_1_00_00_0);
    apply(1, 3'b010, 0, 0); #1 chk_out("R5/R7 dev s0", 8'b01_1_00_00_0);
    apply(1, 3'b010, 1, 0); #1 chk_out("R5/R7 dev s1", 8'b01_0_00_00_0);
    apply(1, 3'b011, 0, 0); #1 chk_out("R4/R6 reserved", 8'b10_1_11_00_0);
    apply(0, 3'b011, 0, 0); #1 chk_out("R3 regs ignored", 8'b10_0_11_11_0);
    apply(0, 3'b000, 0, 1); #1 chk_out("R3 regs ignored so", 8'b00_1_00_00_1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule